// File: doc/BRIEF.md
# Dataflow Instruction Buffer Node

One execution tile of a spatial dataflow array. The tile holds preloaded instructions for several blocks that are in flight at once. An instruction never names where its inputs come from. Instead it names up to two consumers: a tile location, a slot in that tile, and the operand position to fill. Operands and predicates reach the tile as messages from the routing network. Each message is written into the addressed slot. A slot becomes eligible once every input it needs is present.

Each cycle the tile picks at most one eligible slot and runs it through a small integer ALU. It then sends one result message for each target named by the instruction. The block that was mapped earliest wins the pick, and the lowest slot inside that block breaks ties. Committing or squashing a block is done by a per-block flush, which empties that block's eight slots so a new block can be mapped into them. An operand that arrives for an empty slot is discarded, and a one-cycle error pulse is raised.

Top module: `df_exec_node`

## Requirements
- R1: The tile holds 64 slots addressed as {block[2:0], inst[2:0]}. Loading a slot marks it occupied, clears its arrival flags and stores its opcode, predicate enable and targets. A target is {node[3:0], inst[2:0], sel[1:0]}.
- R2: An instruction issues only when all of its inputs are present: left and right for opcodes 0 to 6, left only for opcode 7. A predicated instruction also needs its predicate.
- R3: Opcode results: 0 add, 1 left minus right, 2 and, 3 or, 4 xor, 5 left shifted left by right[4:0], 6 signed left greater than right giving 1 or 0, 7 move left.
- R4: An operand selector of 2 delivers a predicate whose value is bit 0 of the data. A predicated instruction that receives 0 never produces a message, and one that receives 1 fires normally.
- R5: At most one instruction issues per cycle. Each enabled target gives one message, target 0 before target 1, on consecutive cycles. Issue stalls while the second message is pending.
- R6: When several slots are ready, the slot in the block mapped earliest wins. Within one block the lowest instruction index wins. A block counts as mapped when the first slot is loaded into an empty block.
- R7: A flush of a block empties all eight of its slots. Operands sent to them afterwards produce no message.
- R8: An operand for an empty slot is discarded and raises drop_err for exactly one cycle, in the cycle after the delivery.
- R9: The first result message appears one cycle after the clock edge that captures the instruction's last missing input, when the output port is idle.
- R10: A flush and an operand for the same block in the same cycle: the flush wins, the operand is discarded and drop_err stays low.
- R11: After reset no message is driven, drop_err is low and every slot is empty.
- R12: An instruction fires at most once per loading. Further operands for it produce no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load one instruction slot |
| ld_block | input | 3 | Block of slot being loaded |
| ld_inst | input | 3 | Index within block |
| ld_op | input | 3 | Opcode |
| ld_pred_en | input | 1 | Instruction waits for a predicate |
| ld_t0_en | input | 1 | Target 0 enabled |
| ld_t0 | input | 9 | Target 0 {node, inst, sel} |
| ld_t1_en | input | 1 | Target 1 enabled |
| ld_t1 | input | 9 | Target 1 {node, inst, sel} |
| op_valid | input | 1 | Operand message valid |
| op_block | input | 3 | Destination block |
| op_inst | input | 3 | Destination index |
| op_sel | input | 2 | 0 left, 1 right, 2 predicate |
| op_data | input | 32 | Operand value |
| flush_valid | input | 1 | Flush a block |
| flush_block | input | 3 | Block to flush |
| out_valid | output | 1 | Result message valid |
| out_tgt | output | 9 | Consumer {node, inst, sel} |
| out_block | output | 3 | Block of producing instruction |
| out_data | output | 32 | Result value |
| drop_err | output | 1 | Operand hit an empty slot |

## Verification
Two collisions are provoked on purpose. The first is a flush and an operand delivery for the same block in the same cycle. The bench then expects no error pulse and no message, and it expects an error once a later operand hits the emptied slot. The second is a pair of instructions that become ready while the port is still sending the second message of an earlier two-target result. They are made ready by predicates delivered during that stall. The bench checks the order in which the three results leave the tile and the cycle of each message against the mapping age and slot index.

// File: rtl/df_node_pkg.sv
package df_node_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR  = 3'd3,
    OP_XOR = 3'd4, OP_SHL = 3'd5, OP_TGT = 3'd6, OP_MOV = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    SEL_LEFT = 2'd0, SEL_RIGHT = 2'd1, SEL_PRED = 2'd2, SEL_NONE = 2'd3
  } sel_e;
endpackage

// File: rtl/df_alu.sv
module df_alu
  import df_node_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int SH_W = $clog2(DATA_W);

  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SHL:  y = a << b[SH_W-1:0];
      OP_TGT:  y = ($signed(a) > $signed(b)) ? DATA_W'(1) : '0;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/df_slot_state.sv
module df_slot_state
  import df_node_pkg::*;
#(
  parameter int BLK_W  = 3,
  parameter int INST_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ld_valid,
  input  logic [BLK_W+INST_W-1:0]   ld_idx,
  input  logic                      ld_need_r,
  input  logic                      ld_need_p,
  input  logic                      op_valid,
  input  logic [BLK_W+INST_W-1:0]   op_idx,
  input  sel_e                      op_sel,
  input  logic                      op_pbit,
  input  logic                      flush_valid,
  input  logic [BLK_W-1:0]          flush_block,
  input  logic                      issue_go,
  input  logic [BLK_W+INST_W-1:0]   issue_idx,
  output logic [(1<<(BLK_W+INST_W))-1:0] ready,
  output logic [(1<<BLK_W)-1:0]     blk_busy,
  output logic                      op_accept,
  output logic                      drop_err
);
  localparam int NB    = 1 << BLK_W;
  localparam int NI    = 1 << INST_W;
  localparam int N     = NB * NI;
  localparam int IDX_W = BLK_W + INST_W;

  logic [N-1:0] vld, has_l, has_r, has_p, need_r, need_p, done;
  logic         flush_hits_op;

  assign flush_hits_op = flush_valid && (flush_block == op_idx[IDX_W-1 -: BLK_W]);
  assign op_accept     = op_valid && vld[op_idx] && !flush_hits_op;

  always_comb begin
    for (int i = 0; i < N; i++)
      ready[i] = vld[i] & ~done[i] & has_l[i] & (has_r[i] | ~need_r[i]) & (has_p[i] | ~need_p[i]);
  end

  for (genvar g = 0; g < NB; g++) begin : g_busy
    assign blk_busy[g] = |vld[g*NI +: NI];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0; has_l <= '0; has_r <= '0; has_p <= '0;
      need_r <= '0; need_p <= '0; done <= '0;
      drop_err <= 1'b0;
    end else begin
      drop_err <= op_valid && !vld[op_idx] && !flush_hits_op;
      for (int i = 0; i < N; i++) begin
        if (flush_valid && ((i / NI) == int'(flush_block))) begin
          vld[i]  <= 1'b0;
          done[i] <= 1'b0;
        end else if (ld_valid && (ld_idx == IDX_W'(i))) begin
          vld[i]    <= 1'b1;
          has_l[i]  <= 1'b0;
          has_r[i]  <= 1'b0;
          has_p[i]  <= 1'b0;
          done[i]   <= 1'b0;
          need_r[i] <= ld_need_r;
          need_p[i] <= ld_need_p;
        end else begin
          if (op_accept && (op_idx == IDX_W'(i))) begin
            unique case (op_sel)
              SEL_LEFT:  has_l[i] <= 1'b1;
              SEL_RIGHT: has_r[i] <= 1'b1;
              SEL_PRED: begin
                has_p[i] <= 1'b1;
                if (!op_pbit) done[i] <= 1'b1;
              end
              default: ;
            endcase
          end
          if (issue_go && (issue_idx == IDX_W'(i))) done[i] <= 1'b1;
        end
      end
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush_valid |=> !blk_busy[$past(flush_block)]); // R7

  AST_ERR_NEEDS_OPERAND: assert property (@(posedge clk) disable iff (rst)
    drop_err |-> $past(op_valid)); // R8
endmodule

// File: rtl/df_issue_sel.sv
module df_issue_sel #(
  parameter int BLK_W  = 3,
  parameter int INST_W = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [(1<<(BLK_W+INST_W))-1:0]  ready,
  input  logic                            map_valid,
  input  logic [BLK_W-1:0]                map_block,
  input  logic [(1<<BLK_W)-1:0]           blk_busy,
  output logic                            grant_any,
  output logic [BLK_W+INST_W-1:0]         grant_idx
);
  localparam int NB    = 1 << BLK_W;
  localparam int NI    = 1 << INST_W;
  localparam int IDX_W = BLK_W + INST_W;

  // older[j][b] set: block j was mapped before block b
  logic [NB-1:0] older [NB];
  logic [NB-1:0] blk_rdy, win;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < NB; j++) older[j] <= '0;
    end else if (map_valid && !blk_busy[map_block]) begin
      for (int j = 0; j < NB; j++) begin
        older[j][map_block] <= 1'b1;
        older[map_block][j] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_brdy
    assign blk_rdy[g] = |ready[g*NI +: NI];
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      win[b] = blk_rdy[b];
      for (int j = 0; j < NB; j++)
        if (j != b && blk_rdy[j] && older[j][b]) win[b] = 1'b0;
    end
  end

  always_comb begin
    logic taken;
    taken     = 1'b0;
    grant_idx = '0;
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < NI; i++)
        if (!taken && win[b] && ready[b*NI + i]) begin
          grant_idx = IDX_W'(b*NI + i);
          taken     = 1'b1;
        end
    grant_any = taken;
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win)); // R6
endmodule

// File: rtl/df_fanout.sv
module df_fanout #(
  parameter int DATA_W = 32,
  parameter int BLK_W  = 3,
  parameter int TGT_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [DATA_W-1:0] data,
  input  logic [BLK_W-1:0]  block,
  input  logic              t0_en,
  input  logic [TGT_W-1:0]  t0,
  input  logic              t1_en,
  input  logic [TGT_W-1:0]  t1,
  output logic              pend,
  output logic              out_valid,
  output logic [TGT_W-1:0]  out_tgt,
  output logic [BLK_W-1:0]  out_block,
  output logic [DATA_W-1:0] out_data
);
  logic [TGT_W-1:0] pend_tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_tgt  <= '0;
      out_valid <= 1'b0;
      out_tgt   <= '0;
      out_block <= '0;
      out_data  <= '0;
    end else if (pend) begin
      out_valid <= 1'b1;
      out_tgt   <= pend_tgt;
      pend      <= 1'b0;
    end else if (go && (t0_en || t1_en)) begin
      out_valid <= 1'b1;
      out_data  <= data;
      out_block <= block;
      out_tgt   <= t0_en ? t0 : t1;
      pend      <= t0_en && t1_en;
      pend_tgt  <= t1;
    end else begin
      out_valid <= 1'b0;
    end
  end

  AST_SECOND_NEXT: assert property (@(posedge clk) disable iff (rst)
    pend |=> (out_valid && !pend)); // R5
endmodule

// File: rtl/df_exec_node.sv
module df_exec_node
  import df_node_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BLK_W  = 3,
  parameter int INST_W = 3,
  parameter int NODE_W = 4
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            ld_valid,
  input  logic [BLK_W-1:0]                ld_block,
  input  logic [INST_W-1:0]               ld_inst,
  input  logic [2:0]                      ld_op,
  input  logic                            ld_pred_en,
  input  logic                            ld_t0_en,
  input  logic [NODE_W+INST_W+1:0]        ld_t0,
  input  logic                            ld_t1_en,
  input  logic [NODE_W+INST_W+1:0]        ld_t1,
  input  logic                            op_valid,
  input  logic [BLK_W-1:0]                op_block,
  input  logic [INST_W-1:0]               op_inst,
  input  logic [1:0]                      op_sel,
  input  logic [DATA_W-1:0]               op_data,
  input  logic                            flush_valid,
  input  logic [BLK_W-1:0]                flush_block,
  output logic                            out_valid,
  output logic [NODE_W+INST_W+1:0]        out_tgt,
  output logic [BLK_W-1:0]                out_block,
  output logic [DATA_W-1:0]               out_data,
  output logic                            drop_err
);
  localparam int NB    = 1 << BLK_W;
  localparam int NI    = 1 << INST_W;
  localparam int N     = NB * NI;
  localparam int IDX_W = BLK_W + INST_W;
  localparam int TGT_W = NODE_W + INST_W + 2;
  localparam int REC_W = 3 + 2 * (1 + TGT_W);

  logic [IDX_W-1:0]  ld_idx, op_idx, grant_idx;
  logic [N-1:0]      ready;
  logic [NB-1:0]     blk_busy;
  logic              op_accept, grant_any, issue_go, fo_pend;
  sel_e              sel;

  logic [DATA_W-1:0] lmem [N];
  logic [DATA_W-1:0] rmem [N];
  logic [REC_W-1:0]  imem [N];

  logic [REC_W-1:0]  rec;
  op_e               iss_op;
  logic [DATA_W-1:0] alu_y;

  assign ld_idx   = {ld_block, ld_inst};
  assign op_idx   = {op_block, op_inst};
  assign sel      = sel_e'(op_sel);
  assign issue_go = grant_any && !fo_pend;

  always_ff @(posedge clk)
    if (op_accept && sel == SEL_LEFT) lmem[op_idx] <= op_data;

  always_ff @(posedge clk)
    if (op_accept && sel == SEL_RIGHT) rmem[op_idx] <= op_data;

  always_ff @(posedge clk)
    if (ld_valid) imem[ld_idx] <= {ld_op, ld_t0_en, ld_t0, ld_t1_en, ld_t1};

  assign rec    = imem[grant_idx];
  assign iss_op = op_e'(rec[REC_W-1 -: 3]);

  df_slot_state #(.BLK_W(BLK_W), .INST_W(INST_W)) u_state (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_idx(ld_idx),
    .ld_need_r(op_e'(ld_op) != OP_MOV), .ld_need_p(ld_pred_en),
    .op_valid(op_valid), .op_idx(op_idx), .op_sel(sel), .op_pbit(op_data[0]),
    .flush_valid(flush_valid), .flush_block(flush_block),
    .issue_go(issue_go), .issue_idx(grant_idx),
    .ready(ready), .blk_busy(blk_busy), .op_accept(op_accept), .drop_err(drop_err)
  );

  df_issue_sel #(.BLK_W(BLK_W), .INST_W(INST_W)) u_sel (
    .clk(clk), .rst(rst), .ready(ready),
    .map_valid(ld_valid), .map_block(ld_block), .blk_busy(blk_busy),
    .grant_any(grant_any), .grant_idx(grant_idx)
  );

  df_alu #(.DATA_W(DATA_W)) u_alu (
    .op(iss_op), .a(lmem[grant_idx]), .b(rmem[grant_idx]), .y(alu_y)
  );

  df_fanout #(.DATA_W(DATA_W), .BLK_W(BLK_W), .TGT_W(TGT_W)) u_fan (
    .clk(clk), .rst(rst), .go(issue_go), .data(alu_y),
    .block(grant_idx[IDX_W-1 -: BLK_W]),
    .t0_en(rec[REC_W-4]), .t0(rec[REC_W-5 -: TGT_W]),
    .t1_en(rec[TGT_W]), .t1(rec[TGT_W-1:0]),
    .pend(fo_pend), .out_valid(out_valid), .out_tgt(out_tgt),
    .out_block(out_block), .out_data(out_data)
  );

  AST_MSG_FROM_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(fo_pend)) |-> $past(issue_go)); // R5

  AST_NO_ERR_ON_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (op_valid && flush_valid && flush_block == op_block) |=> !drop_err); // R10
endmodule

// File: tb/tb_df_exec_node.sv
module tb_df_exec_node;
  logic        clk = 1'b0;
  logic        rst;
  logic        ld_valid, ld_pred_en, ld_t0_en, ld_t1_en;
  logic [2:0]  ld_block, ld_inst, ld_op;
  logic [8:0]  ld_t0, ld_t1;
  logic        op_valid;
  logic [2:0]  op_block, op_inst;
  logic [1:0]  op_sel;
  logic [31:0] op_data;
  logic        flush_valid;
  logic [2:0]  flush_block;
  logic        out_valid, drop_err;
  logic [8:0]  out_tgt;
  logic [2:0]  out_block;
  logic [31:0] out_data;

  int checks = 0, errors = 0, cyc = 0, wr = 0, rd = 0, last_cyc = 0;
  bit finished = 0;
  logic [8:0]  lg_t [256];
  logic [2:0]  lg_b [256];
  logic [31:0] lg_d [256];
  int          lg_c [256];

  always #4 clk = ~clk;

  df_exec_node dut (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_block(ld_block), .ld_inst(ld_inst), .ld_op(ld_op),
    .ld_pred_en(ld_pred_en), .ld_t0_en(ld_t0_en), .ld_t0(ld_t0),
    .ld_t1_en(ld_t1_en), .ld_t1(ld_t1),
    .op_valid(op_valid), .op_block(op_block), .op_inst(op_inst),
    .op_sel(op_sel), .op_data(op_data),
    .flush_valid(flush_valid), .flush_block(flush_block),
    .out_valid(out_valid), .out_tgt(out_tgt), .out_block(out_block),
    .out_data(out_data), .drop_err(drop_err)
  );

  always @(negedge clk) begin
    cyc++;
    if (!rst && out_valid && wr < 256) begin
      lg_t[wr] = out_tgt; lg_b[wr] = out_block; lg_d[wr] = out_data; lg_c[wr] = cyc;
      wr++;
    end
  end

  function automatic logic [31:0] alu_ref(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a << b[4:0];
      3'd6: return ($signed(a) > $signed(b)) ? 32'd1 : 32'd0;
      default: return a;
    endcase
  endfunction

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] b, input logic [2:0] i, input logic [2:0] op, input logic pe,
                      input logic t0e, input logic [8:0] t0, input logic t1e, input logic [8:0] t1);
    ld_valid = 1; ld_block = b; ld_inst = i; ld_op = op; ld_pred_en = pe;
    ld_t0_en = t0e; ld_t0 = t0; ld_t1_en = t1e; ld_t1 = t1;
    step();
    ld_valid = 0;
  endtask

  task automatic send_op(input logic [2:0] b, input logic [2:0] i, input logic [1:0] s, input logic [31:0] d);
    op_valid = 1; op_block = b; op_inst = i; op_sel = s; op_data = d;
    step();
    op_valid = 0;
    last_cyc = cyc;
  endtask

  task automatic flush(input logic [2:0] b);
    flush_valid = 1; flush_block = b;
    step();
    flush_valid = 0;
  endtask

  task automatic flush_all();
    for (int b = 0; b < 8; b++) flush(3'(b));
  endtask

  task automatic expect_msg(input int ecyc, input logic [8:0] t, input logic [2:0] b,
                            input logic [31:0] d, input string req);
    int w;
    w = 0;
    while (wr <= rd && w < 40) begin step(); w++; end
    if (wr <= rd) begin
      chk(0, {req, " message missing"}, 0, {t, b});
    end else begin
      chk({lg_t[rd], lg_b[rd], lg_d[rd]} == {t, b, d}, {req, " message content"},
          {lg_t[rd], lg_b[rd], lg_d[rd]}, {t, b, d});
      if (ecyc >= 0)
        chk(lg_c[rd] == ecyc, {req, " message cycle"}, lg_c[rd], ecyc);
      rd++;
    end
  endtask

  task automatic quiet(input int n, input string req);
    for (int k = 0; k < n; k++) step();
    chk(wr == rd, {req, " unexpected message"}, wr - rd, 0);
    rd = wr;
  endtask

  // x mapped first, y second, z a plain two-target move that holds the port
  task automatic prio_case(input logic [2:0] bx, input logic [2:0] ix, input logic [2:0] by,
                           input logic [2:0] iy, input logic [2:0] bz, input bit x_wins);
    int c1;
    flush_all();
    load(bx, ix, 3'd7, 1, 1, 9'h101, 0, 9'h0);
    load(by, iy, 3'd7, 1, 1, 9'h102, 0, 9'h0);
    load(bz, 3'd7, 3'd7, 0, 1, 9'h0A4, 1, 9'h0C5);
    send_op(bx, ix, 2'd0, 32'hAAAA_0001);
    send_op(by, iy, 2'd0, 32'hBBBB_0002);
    send_op(bz, 3'd7, 2'd0, 32'hCCCC_0003);
    c1 = last_cyc;
    send_op(bx, ix, 2'd2, 32'd1);
    send_op(by, iy, 2'd2, 32'd1);
    expect_msg(c1 + 1, 9'h0A4, bz, 32'hCCCC_0003, "R5 first target");
    expect_msg(c1 + 2, 9'h0C5, bz, 32'hCCCC_0003, "R5 second target back to back");
    if (x_wins) begin
      expect_msg(c1 + 3, 9'h101, bx, 32'hAAAA_0001, "R6 winner after stall");
      expect_msg(c1 + 4, 9'h102, by, 32'hBBBB_0002, "R6 loser next");
    end else begin
      expect_msg(c1 + 3, 9'h102, by, 32'hBBBB_0002, "R6 winner after stall");
      expect_msg(c1 + 4, 9'h101, bx, 32'hAAAA_0001, "R6 loser next");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; ld_valid = 0; op_valid = 0; flush_valid = 0;
    ld_block = 0; ld_inst = 0; ld_op = 0; ld_pred_en = 0;
    ld_t0_en = 0; ld_t0 = 0; ld_t1_en = 0; ld_t1 = 0;
    op_block = 0; op_inst = 0; op_sel = 0; op_data = 0; flush_block = 0;
    repeat (3) step();
    rst = 0;
    step();

    // R11: reset state, all slots empty
    chk(out_valid == 0, "R11 out_valid after reset", out_valid, 0);
    chk(drop_err == 0, "R11 drop_err after reset", drop_err, 0);
    send_op(3'd2, 3'd3, 2'd0, 32'd5);
    chk(drop_err == 1, "R11 R8 operand to empty slot after reset", drop_err, 1);
    step();
    chk(drop_err == 0, "R8 error lasts one cycle", drop_err, 0);
    quiet(3, "R11");

    // R2 and R9: binary op waits for the right operand
    load(3'd1, 3'd4, 3'd0, 0, 1, 9'h1F3, 0, 9'h0);
    send_op(3'd1, 3'd4, 2'd0, 32'd100);
    quiet(5, "R2 missing right operand");
    send_op(3'd1, 3'd4, 2'd1, 32'd23);
    expect_msg(last_cyc + 1, 9'h1F3, 3'd1, 32'd123, "R2 R9 add fires on completion");

    // R12: a fired instruction stays fired
    send_op(3'd1, 3'd4, 2'd0, 32'd7);
    chk(drop_err == 0, "R12 operand to fired slot is no error", drop_err, 0);
    quiet(4, "R12 refire");

    // R4: predicate false suppresses, true fires
    load(3'd0, 3'd2, 3'd7, 1, 1, 9'h055, 1, 9'h066);
    send_op(3'd0, 3'd2, 2'd0, 32'hDEAD);
    quiet(3, "R4 waiting for predicate");
    send_op(3'd0, 3'd2, 2'd2, 32'hFFFF_FFFE);
    quiet(5, "R4 false predicate");
    load(3'd0, 3'd3, 3'd7, 1, 1, 9'h077, 0, 9'h0);
    send_op(3'd0, 3'd3, 2'd2, 32'd1);
    quiet(2, "R4 predicate alone not enough");
    send_op(3'd0, 3'd3, 2'd0, 32'hBEEF);
    expect_msg(last_cyc + 1, 9'h077, 3'd0, 32'hBEEF, "R4 R9 true predicate fires");

    // R3: signed compare corners
    load(3'd2, 3'd0, 3'd6, 0, 1, 9'h011, 0, 9'h0);
    send_op(3'd2, 3'd0, 2'd0, 32'hFFFF_FFFB);
    send_op(3'd2, 3'd0, 2'd1, 32'd3);
    expect_msg(last_cyc + 1, 9'h011, 3'd2, 32'd0, "R3 test -5 > 3");
    load(3'd2, 3'd1, 3'd6, 0, 1, 9'h012, 0, 9'h0);
    send_op(3'd2, 3'd1, 2'd1, 32'hFFFF_FFFB);
    send_op(3'd2, 3'd1, 2'd0, 32'd3);
    expect_msg(last_cyc + 1, 9'h012, 3'd2, 32'd1, "R3 test 3 > -5");
    load(3'd2, 3'd2, 3'd6, 0, 1, 9'h013, 0, 9'h0);
    send_op(3'd2, 3'd2, 2'd0, 32'd9);
    send_op(3'd2, 3'd2, 2'd1, 32'd9);
    expect_msg(last_cyc + 1, 9'h013, 3'd2, 32'd0, "R3 test equal");

    // R7: flush empties the block
    load(3'd7, 3'd0, 3'd7, 0, 1, 9'h0F0, 0, 9'h0);
    flush(3'd7);
    send_op(3'd7, 3'd0, 2'd0, 32'd44);
    chk(drop_err == 1, "R7 R8 operand after flush flagged", drop_err, 1);
    quiet(4, "R7 flushed slot");

    // R10: flush and operand to the same block in one cycle
    load(3'd6, 3'd1, 3'd7, 0, 1, 9'h0E1, 0, 9'h0);
    flush_valid = 1; flush_block = 3'd6;
    op_valid = 1; op_block = 3'd6; op_inst = 3'd1; op_sel = 2'd0; op_data = 32'd77;
    step();
    flush_valid = 0; op_valid = 0;
    chk(drop_err == 0, "R10 no error when flush wins", drop_err, 0);
    quiet(4, "R10 flushed operand");
    send_op(3'd6, 3'd1, 2'd0, 32'd78);
    chk(drop_err == 1, "R10 slot empty after collision", drop_err, 1);

    // R6 and R5: priority under a busy output port
    prio_case(3'd5, 3'd6, 3'd2, 3'd0, 3'd0, 1);
    prio_case(3'd1, 3'd5, 3'd6, 3'd0, 3'd4, 1);
    prio_case(3'd3, 3'd5, 3'd3, 3'd2, 3'd0, 0);

    // R1 R3 R5 R9: constrained random single-instruction traffic
    flush_all();
    for (int it = 0; it < 40; it++) begin
      logic [2:0] b, i, op;
      logic [8:0] t0, t1;
      logic t1e, pe;
      logic [31:0] a, bv;
      b = 3'($urandom); i = 3'($urandom); op = 3'($urandom);
      t0 = {4'($urandom), 3'($urandom), 2'($urandom % 3)};
      t1 = {4'($urandom), 3'($urandom), 2'($urandom % 3)};
      t1e = 1'($urandom); pe = ($urandom % 3) == 0;
      a = $urandom; bv = (it % 4 == 0) ? a : $urandom;
      flush(b);
      load(b, i, op, pe, 1, t0, t1e, t1);
      if (pe) send_op(b, i, 2'd2, 32'd1);
      if (op == 3'd7) send_op(b, i, 2'd0, a);
      else if ($urandom % 2) begin
        send_op(b, i, 2'd0, a); send_op(b, i, 2'd1, bv);
      end else begin
        send_op(b, i, 2'd1, bv); send_op(b, i, 2'd0, a);
      end
      expect_msg(last_cyc + 1, t0, b, alu_ref(op, a, bv), "R1 R3 R9 random result");
      if (t1e) expect_msg(last_cyc + 2, t1, b, alu_ref(op, a, bv), "R5 random second target");
      quiet(1, "R5 random extra message");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule